// File: doc/BRIEF.md
# Windowed Watchdog Timer with Lock-After-First-Write Setup

The block is a watchdog for a small microcontroller. Software programs a setup register once after reset. That register chooses whether the counter advances on a slow reference tick or on every bus clock, and whether servicing is restricted to a late window. Software then keeps the system alive by writing a two-byte key to a service register before the counter runs out. If the counter expires, or if software services in the wrong way, the block raises a one-cycle reset request for the system reset controller.

In window mode, a key that arrives too early counts as a fault rather than as a service. This catches runaway code that services the watchdog in a tight loop. A reset request returns the whole block to its reset state, including the setup lock, so the next boot can program the watchdog again.

Top module: `wdog_win_top`

## Requirements
- R1: The setup register at address `CFG_ADDR` (default 0) holds `clk_sel` in bit 0 and `win_en` in bit 1. Only the first write after reset is stored. Every later setup write is ignored and leaves `cfg_rdata_o` unchanged.
- R2: With `clk_sel`=0, the count advances only in cycles where `tick_i` is high. With `clk_sel`=1, it advances in every cycle.
- R3: Writing 0x55 and then 0xAA to the service address `SVC_ADDR` (default 1) clears the count to zero. The next expiry then follows exactly `PERIOD` steps after the 0xAA write.
- R4: In window mode (`win_en`=1 and `clk_sel`=1), a key sequence is accepted when the count is at least `PERIOD*3/4`.
- R5: In window mode, any service write while the count is below `PERIOD*3/4` raises `rst_req_o` in the following cycle. This includes a write at a count of `PERIOD*3/4-1`.
- R6: With `win_en`=1 and `clk_sel`=0, the block behaves as in normal mode, and a key sequence is accepted at any count.
- R7: When the count reaches `PERIOD` steps without a service, `rst_req_o` goes high in the cycle after the step that completes the period.
- R8: A service write of any value other than 0x55 or 0xAA raises `rst_req_o` in the following cycle. So does a 0xAA write that is not preceded by 0x55.
- R9: `rst_req_o` is high for exactly one cycle. Writes made during that cycle are ignored. The request clears the count, the key state, the setup bits and the lock, so `cfg_rdata_o` reads 0 afterwards.
- R10: `cfg_rdata_o` always shows the stored setup bits, with bits 7:2 reading as zero.
- R11: If a completing 0xAA write lands on the same step in which the period would expire, the service wins and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow reference tick enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Setup register read value |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Two events can fall on the same clock edge: the step that completes the timeout period and the 0xAA write that completes a service. The bench provokes this by starting a bus-clock count and placing 0x55 one cycle before the final step and 0xAA exactly on it. A correct design shows no reset request in the following cycle, and the next expiry comes a full period later. The window boundary is also probed one count on each side of three quarters of the period. At that boundary, an early-write fault competes with acceptance of the key.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_st_e;

  typedef struct packed {
    logic win_en;
    logic clk_sel;
  } cfg_t;
endpackage

// File: rtl/wdog_cfg_lock.sv
module wdog_cfg_lock
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CFG_BITS = $bits(cfg_t);

  cfg_t cfg_q;
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else if (clr_i) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else if (wr_i && !locked_q) begin
      cfg_q    <= cfg_t'(wdata_i[CFG_BITS-1:0]);
      locked_q <= 1'b1;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(DATA_W-CFG_BITS){1'b0}}, cfg_q};

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !clr_i) |=> $stable(cfg_q)) else $error("lock"); // R1
  AST_CLR_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!locked_q && cfg_q == '0)) else $error("clr"); // R9
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              early_i,
  output logic              svc_ok_o,
  output logic              key_err_o
);
  key_st_e st_q, st_d;
  logic    ok, err;

  always_comb begin
    st_d = st_q;
    ok   = 1'b0;
    err  = 1'b0;
    if (wr_i) begin
      if (early_i) begin
        err = 1'b1;
      end else if (wdata_i == KEY_FIRST) begin
        st_d = KEY_ARMED;
      end else if (wdata_i == KEY_SECOND && st_q == KEY_ARMED) begin
        ok   = 1'b1;
        st_d = KEY_IDLE;
      end else begin
        err = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= KEY_IDLE;
    else if (clr_i)  st_q <= KEY_IDLE;
    else             st_q <= st_d;
  end

  assign svc_ok_o  = ok;
  assign key_err_o = err;

  AST_OK_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_ok_o |-> (st_q == KEY_ARMED)) else $error("arm"); // R8
  AST_OK_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(svc_ok_o && key_err_o)) else $error("excl"); // R3
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned PERIOD = 1024,
  localparam int unsigned CNT_W    = $clog2(PERIOD),
  localparam int unsigned WIN_OPEN = PERIOD - PERIOD / 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             svc_i,
  input  logic             step_i,
  input  logic             win_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             early_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || svc_i)   cnt_q <= '0;
    else if (step_i) begin
      if (cnt_q == CNT_W'(PERIOD - 1)) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign early_o  = win_en_i && (cnt_q < CNT_W'(WIN_OPEN));
  assign expire_o = step_i && (cnt_q == CNT_W'(PERIOD - 1));

  AST_SVC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_i |=> (cnt_q == '0)) else $error("svc"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !svc_i && !clr_i) |=> $stable(cnt_q)) else $error("hold"); // R2
endmodule

// File: rtl/wdog_win_top.sv
module wdog_win_top
  import wdog_pkg::*;
#(
  parameter int unsigned PERIOD   = 1024,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CFG_ADDR = 0,
  parameter int unsigned SVC_ADDR = 1,
  localparam int unsigned CNT_W   = $clog2(PERIOD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        cfg_rdata_o,
  output logic              rst_req_o
);
  logic             rst_req_q;
  logic             wr_ok, cfg_wr, svc_wr;
  logic             fault;
  cfg_t             cfg;
  logic             win_act, step;
  logic             early, expire, svc_ok, key_err;
  logic [CNT_W-1:0] cnt;

  // writes are dropped while the request is out
  assign wr_ok  = wr_en_i && !rst_req_q;
  assign cfg_wr = wr_ok && (wr_addr_i == ADDR_W'(CFG_ADDR));
  assign svc_wr = wr_ok && (wr_addr_i == ADDR_W'(SVC_ADDR));

  // window only valid on bus clock
  assign win_act = cfg.win_en && cfg.clk_sel;
  assign step    = cfg.clk_sel ? 1'b1 : tick_i;

  assign fault = !rst_req_q && (key_err || (expire && !svc_ok));

  wdog_cfg_lock u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fault),
    .wr_i    (cfg_wr),
    .wdata_i (wr_data_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  wdog_key_seq u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (fault),
    .wr_i      (svc_wr),
    .wdata_i   (wr_data_i),
    .early_i   (early),
    .svc_ok_o  (svc_ok),
    .key_err_o (key_err)
  );

  wdog_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (fault),
    .svc_i    (svc_ok),
    .step_i   (step),
    .win_en_i (win_act),
    .cnt_o    (cnt),
    .early_o  (early),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= fault;
  end

  assign rst_req_o = rst_req_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o) else $error("pulse"); // R9
  AST_EARLY_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_wr && win_act && cnt < CNT_W'(PERIOD - PERIOD / 4)) |=> rst_req_o)
    else $error("early"); // R5
  AST_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_q && step && cnt == CNT_W'(PERIOD - 1) && !svc_ok) |=> rst_req_o)
    else $error("expire"); // R7
  AST_SVC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_ok && !key_err) |=> !rst_req_o) else $error("svcwin"); // R11
  AST_RDATA_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[7:2] == '0) else $error("pad"); // R10
endmodule

// File: tb/tb_wdog_win_top.sv
`timescale 1ns/1ps
module tb_wdog_win_top;
  localparam int P  = 64;
  localparam int WO = P - P / 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rdata;
  logic req;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  wdog_win_top #(.PERIOD(P), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cfg_rdata_o(rdata), .rst_req_o(req)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // one write on the next rising edge, returns at the following falling edge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles until the request shows, 0 if not within lim
  task automatic cycles_to_req(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (req && n == 0) n = i;
      if (n != 0) break;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(rdata == 8'h00, "R10 reset read", rdata, 0);
    chk(req == 1'b0, "R9 reset req", req, 0);
  endtask

  task automatic t_write_once();
    int n;
    do_reset();
    wr(0, 8'hFF);
    chk(rdata == 8'h03, "R10 pad bits", rdata, 3);
    wr(0, 8'h00);
    chk(rdata == 8'h03, "R1 second write ignored", rdata, 3);
    do_reset();
    wr(0, 8'h01);
    wr(0, 8'h03);
    chk(rdata == 8'h01, "R1 lock win bit", rdata, 1);
    // window must stay off: early service accepted
    wr(1, 8'h55); wr(1, 8'hAA);
    chk(req == 1'b0, "R1 window not set", req, 0);
    cycles_to_req(P + 4, n);
    chk(n == P, "R3 expiry after service", n, P);
    @(negedge clk);
    chk(req == 1'b0, "R9 one cycle", req, 0);
    chk(rdata == 8'h00, "R9 lock cleared", rdata, 0);
    wr(0, 8'h02);
    chk(rdata == 8'h02, "R9 rewritable", rdata, 2);
  endtask

  task automatic t_bus_timeout();
    int n;
    do_reset();
    wr(0, 8'h01);
    cycles_to_req(P + 4, n);
    chk(n == P, "R7 bus clock expiry", n, P);
  endtask

  task automatic t_tick_mode();
    do_reset();
    wr(0, 8'h00);
    idle(3 * P);
    chk(req == 1'b0, "R2 no tick no step", req, 0);
    for (int i = 1; i <= P; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      idle(2);
      if (i == P - 1) chk(req == 1'b0, "R2 before last tick", req, 0);
    end
    // request came 1 cycle after last tick edge; after 2 idle it is gone
    chk(rdata == 8'h00, "R9 cfg cleared after expiry", rdata, 0);
  endtask

  task automatic t_tick_expiry_edge();
    do_reset();
    for (int i = 1; i <= P; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      if (i == P) chk(req == 1'b1, "R7 tick expiry", req, 1);
      else if (req) chk(1'b0, "R7 early expiry", i, P);
      idle(1);
    end
  endtask

  task automatic t_window_ok();
    int n;
    do_reset();
    wr(0, 8'h03);
    idle(WO);
    wr(1, 8'h55); wr(1, 8'hAA);
    chk(req == 1'b0, "R4 in-window accept", req, 0);
    cycles_to_req(P + 4, n);
    chk(n == P, "R4 count cleared", n, P);
  endtask

  task automatic t_window_early();
    do_reset();
    wr(0, 8'h03);
    idle(WO - 1);
    wr(1, 8'h55);
    chk(req == 1'b1, "R5 one below window", req, 1);
    do_reset();
    wr(0, 8'h03);
    wr(1, 8'h55);
    chk(req == 1'b1, "R5 immediate write", req, 1);
    wr(1, 8'h12);
    chk(req == 1'b0, "R9 write in req cycle ignored", req, 0);
  endtask

  task automatic t_window_tick();
    int n;
    do_reset();
    wr(0, 8'h02);
    wr(1, 8'h55); wr(1, 8'hAA);
    chk(req == 1'b0, "R6 window ignored on tick", req, 0);
    chk(rdata == 8'h02, "R6 cfg read", rdata, 2);
    wr(0, 8'h01);
    cycles_to_req(20, n);
    chk(n == 0, "R6 still tick mode", n, 0);
  endtask

  task automatic t_bad_keys();
    do_reset();
    wr(0, 8'h01);
    wr(1, 8'h12);
    chk(req == 1'b1, "R8 wrong value", req, 1);
    do_reset();
    wr(0, 8'h01);
    wr(1, 8'hAA);
    chk(req == 1'b1, "R8 AA without 55", req, 1);
    do_reset();
    wr(0, 8'h01);
    wr(1, 8'h55); wr(1, 8'hAA); wr(1, 8'hAA);
    chk(req == 1'b1, "R8 repeated AA", req, 1);
  endtask

  task automatic t_same_cycle();
    int n;
    do_reset();
    wr(0, 8'h01);
    idle(P - 2);
    wr(1, 8'h55);
    wr(1, 8'hAA);
    chk(req == 1'b0, "R11 service beats expiry", req, 0);
    cycles_to_req(P + 4, n);
    chk(n == P, "R11 next expiry", n, P);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_write_once();
    t_bus_timeout();
    t_tick_mode();
    t_tick_expiry_edge();
    t_window_ok();
    t_window_early();
    t_window_tick();
    t_bad_keys();
    t_same_cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule